// File: doc/BRIEF.md
# Input Capture Unit with Time-Base Reset

This block watches one external input line and records the value of a free-running time base when a qualifying transition arrives on it. A 4-bit mode field selects which transitions qualify and what follows from them: a copy into the capture buffer, a sticky interrupt flag, an optional clear of the time base, or a one-cycle trigger pulse for other logic. The input is asynchronous. It passes through a synchronizer before edge detection, so every action occurs a fixed number of clocks after the pin moves.

Mode codes give plain edge capture on either polarity, period measurement, pulse-width measurement of a high or a low pulse, state-change capture on both polarities, and a trigger mode that clears and starts the time base without raising the flag. The reset-on-capture enable applies to the capture modes. Pulse-width mode ignores it and clears the time base at the start of each pulse. The unit keeps repeating its action on every qualifying transition until the mode changes or reset is applied.

Top module: `icap_unit`

## Requirements
- R1: The pin goes through a two-stage synchronizer. A pin change made before rising clock edge k takes effect on buffer, count, flag and trigger at edge k+2. No output reflects it after edge k+1.
- R2: Modes 0001 and 0011 act on rising pin transitions. Modes 0010 and 0100 act on falling transitions. An acting transition copies the count into the buffer and sets the flag, and the opposite transition does nothing.
- R3: Mode 0101 (period) acts on rising transitions only, with capture and flag.
- R4: In modes 0001–0101 and 1000, an acting transition with reset-enable set clears the count to 0 on the capture edge. With reset-enable clear, the count advances by one as usual.
- R5: Mode 0110 measures a high pulse and mode 0111 measures a low pulse. The starting transition clears the count with no capture and no flag. The ending transition captures and sets the flag without clearing the count. Reset-enable has no effect in these modes.
- R6: Mode 1000 acts on both transitions, with capture and flag.
- R7: Mode 1110 acts on rising transitions and mode 1111 on falling transitions. Each such transition gives a one-cycle trigger pulse, captures, clears the count and leaves the flag unchanged. After it the time base counts even with the timer enable low, until the mode leaves 1110/1111.
- R8: The trigger output is high only in the cycle after a trigger-mode transition.
- R9: Mode 0000 and the unassigned codes 1001–1101 produce no capture, no flag, no trigger and no clear. The buffer keeps its value.
- R10: The flag stays set until the clear strobe. A clear strobe in the same cycle as a new flag-setting event wins, and the flag reads 0.
- R11: The count advances by one per clock while the timer enable is high and wraps at full scale. It holds while the enable is low, except where R7 applies. Writing the mode field never alters it.
- R12: After synchronous reset, buffer, count, flag and trigger all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cap_i | input | 1 | Asynchronous capture pin |
| mode_i | input | 4 | Mode select code |
| rst_en_i | input | 1 | Clear the time base on capture |
| tmr_en_i | input | 1 | Time-base count enable |
| flag_clr_i | input | 1 | Flag clear strobe |
| buf_o | output | 16 | Capture buffer |
| count_o | output | 16 | Time-base count |
| flag_o | output | 1 | Sticky capture interrupt flag |
| trig_o | output | 1 | One-cycle special event trigger |

## Verification
The assertions check properties on every cycle:
- the trigger appears only after a trigger-mode cycle and never lasts two cycles;
- the flag never rises together with a trigger;
- the flag is sticky, and a clear always wins;
- the buffer holds while the unit is disabled;
- the count only steps by one or drops to zero, and stays frozen when neither enable nor trigger mode applies.

Which transition each mode selects, whether reset-enable is obeyed or ignored, the exact capture value and the three-edge latency come from the mode table and the pin history. Only the bench scenarios can show these, because they compare against the count sampled just before the acting edge.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int unsigned MODE_W = 4;
    typedef logic [MODE_W-1:0] mode_t;

    // Mode codes; the values are what software writes into the mode field.
    localparam mode_t MODE_OFF     = 4'b0000;
    localparam mode_t MODE_RISE_A  = 4'b0001;
    localparam mode_t MODE_FALL_A  = 4'b0010;
    localparam mode_t MODE_RISE_B  = 4'b0011;
    localparam mode_t MODE_FALL_B  = 4'b0100;
    localparam mode_t MODE_PERIOD  = 4'b0101;
    localparam mode_t MODE_PW_HIGH = 4'b0110;
    localparam mode_t MODE_PW_LOW  = 4'b0111;
    localparam mode_t MODE_CHANGE  = 4'b1000;
    localparam mode_t MODE_TRIG_R  = 4'b1110;
    localparam mode_t MODE_TRIG_F  = 4'b1111;

    // What a single pin transition does in the current mode.
    typedef struct packed {
        logic cap;        // copy count into buffer
        logic rst_force;  // clear the time base unconditionally
        logic rst_opt;    // clear the time base if reset-enable is set
        logic flg;        // set the interrupt flag
        logic trg;        // emit the trigger pulse
    } edge_act_t;

    localparam edge_act_t ACT_NONE    = '0;
    localparam edge_act_t ACT_CAPTURE = '{cap: 1'b1, rst_force: 1'b0, rst_opt: 1'b1, flg: 1'b1, trg: 1'b0};
    localparam edge_act_t ACT_PW_START = '{cap: 1'b0, rst_force: 1'b1, rst_opt: 1'b0, flg: 1'b0, trg: 1'b0};
    localparam edge_act_t ACT_PW_END  = '{cap: 1'b1, rst_force: 1'b0, rst_opt: 1'b0, flg: 1'b1, trg: 1'b0};
    localparam edge_act_t ACT_TRIGGER = '{cap: 1'b1, rst_force: 1'b1, rst_opt: 1'b0, flg: 1'b0, trg: 1'b1};

    // Gate an action set with the strobe of the transition it belongs to.
    function automatic edge_act_t gate_act(edge_act_t act, logic hit);
        return hit ? act : ACT_NONE;
    endfunction

endpackage

// File: rtl/icap_edge.sv
module icap_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [N-1:0] sync;
        logic         last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin_i;
        for (int i = 1; i < int'(N); i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.last = st_q.sync[N-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o =  st_q.sync[N-1] & ~st_q.last;
    assign fall_o = ~st_q.sync[N-1] &  st_q.last;

endmodule

// File: rtl/icap_decode.sv
module icap_decode
    import icap_pkg::*;
(
    input  mode_t     mode_i,
    output edge_act_t rise_act_o,
    output edge_act_t fall_act_o,
    output logic      trig_mode_o
);

    always_comb begin
        rise_act_o  = ACT_NONE;
        fall_act_o  = ACT_NONE;
        trig_mode_o = 1'b0;
        case (mode_i)
            MODE_RISE_A, MODE_RISE_B, MODE_PERIOD: begin
                rise_act_o = ACT_CAPTURE;
            end
            MODE_FALL_A, MODE_FALL_B: begin
                fall_act_o = ACT_CAPTURE;
            end
            MODE_PW_HIGH: begin
                rise_act_o = ACT_PW_START;
                fall_act_o = ACT_PW_END;
            end
            MODE_PW_LOW: begin
                fall_act_o = ACT_PW_START;
                rise_act_o = ACT_PW_END;
            end
            MODE_CHANGE: begin
                rise_act_o = ACT_CAPTURE;
                fall_act_o = ACT_CAPTURE;
            end
            MODE_TRIG_R: begin
                rise_act_o  = ACT_TRIGGER;
                trig_mode_o = 1'b1;
            end
            MODE_TRIG_F: begin
                fall_act_o  = ACT_TRIGGER;
                trig_mode_o = 1'b1;
            end
            default: begin
                rise_act_o = ACT_NONE;
                fall_act_o = ACT_NONE;
            end
        endcase
    end

endmodule

// File: rtl/icap_timebase.sv
module icap_timebase #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             clear_i,
    input  logic             run_set_i,
    input  logic             run_allow_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;   // started by a trigger event
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_allow_i & (st_q.run | run_set_i);
        if (clear_i) begin
            st_d.count = '0;
        end else if (en_i | st_q.run) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cap_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              rst_en_i,
    input  logic              tmr_en_i,
    input  logic              flag_clr_i,
    output logic [CNT_W-1:0]  buf_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              flag_o,
    output logic              trig_o
);

    logic      rise, fall;
    edge_act_t rise_act, fall_act, ev;
    logic      trig_mode;
    logic      clear_tb;

    icap_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pin_i  (cap_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    icap_decode u_decode (
        .mode_i      (mode_i),
        .rise_act_o  (rise_act),
        .fall_act_o  (fall_act),
        .trig_mode_o (trig_mode)
    );

    assign ev       = edge_act_t'(gate_act(rise_act, rise) | gate_act(fall_act, fall));
    assign clear_tb = ev.rst_force | (ev.rst_opt & rst_en_i);

    icap_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (tmr_en_i),
        .clear_i     (clear_tb),
        .run_set_i   (ev.trg),
        .run_allow_i (trig_mode),
        .count_o     (count_o)
    );

    typedef struct packed {
        logic [CNT_W-1:0] cbuf;
        logic             flag;
        logic             trig;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = ev.trg;
        if (ev.cap) begin
            st_d.cbuf = count_o;
        end
        if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end else if (ev.flg) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_o  = st_q.cbuf;
    assign flag_o = st_q.flag;
    assign trig_o = st_q.trig;

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [3:0]       mode_i,
    input logic             tmr_en_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] buf_o,
    input logic [CNT_W-1:0] count_o,
    input logic             flag_o,
    input logic             trig_o
);

    p_trig_mode_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && trig_o) |-> ($past(mode_i) == 4'b1110 || $past(mode_i) == 4'b1111));

    p_trig_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_o |=> !trig_o);

    p_trig_no_flag_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && trig_o) |-> !$rose(flag_o));

    p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        flag_clr_i |=> !flag_o);

    p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_o && !flag_clr_i) |=> flag_o);

    p_off_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(mode_i) == 4'b0000) |-> ($stable(buf_o) && !$rose(flag_o)));

    p_count_step_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && count_o != $past(count_o))
            |-> (count_o == $past(count_o) + 1'b1 || count_o == '0));

    p_count_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(tmr_en_i) && $past(mode_i[3:1]) != 3'b111
            && $past(mode_i[3:1], 2) != 3'b111 && count_o != '0) |-> $stable(count_o));

endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .mode_i     (mode_i),
    .tmr_en_i   (tmr_en_i),
    .flag_clr_i (flag_clr_i),
    .buf_o      (buf_o),
    .count_o    (count_o),
    .flag_o     (flag_o),
    .trig_o     (trig_o)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;

    localparam int unsigned CNT_W = 16;
    localparam int unsigned NVEC  = 22;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             cap_i = 1'b0;
    logic [3:0]       mode_i = 4'b0000;
    logic             rst_en_i = 1'b0;
    logic             tmr_en_i = 1'b0;
    logic             flag_clr_i = 1'b0;
    logic [CNT_W-1:0] buf_o;
    logic [CNT_W-1:0] count_o;
    logic             flag_o;
    logic             trig_o;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #10 clk_i = ~clk_i;

    icap_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cap_i      (cap_i),
        .mode_i     (mode_i),
        .rst_en_i   (rst_en_i),
        .tmr_en_i   (tmr_en_i),
        .flag_clr_i (flag_clr_i),
        .buf_o      (buf_o),
        .count_o    (count_o),
        .flag_o     (flag_o),
        .trig_o     (trig_o)
    );

    // {mode[3:0], ren, rising, exp_cap, exp_clear, exp_flag, exp_trig, req[3:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {4'b0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 rising acts
        {4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 falling ignored
        {4'b0011, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        {4'b0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        {4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 rising ignored
        {4'b0100, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 clear on capture
        {4'b0001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4},  // R4
        {4'b0101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
        {4'b0101, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 with R4
        {4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 falling ignored
        {4'b0110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 start clears
        {4'b0110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 ren ignored at end
        {4'b0111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        {4'b1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        {4'b1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
        {4'b1110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd7},  // R7
        {4'b1110, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 wrong edge
        {4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd7},  // R7
        {4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 no trigger
        {4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 disabled
        {4'b1011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}   // R9 unassigned code
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Park the pin at a level while disabled, then select the mode and clear the flag.
    task automatic prep(input logic [3:0] m, input logic ren, input logic lvl);
        @(negedge clk_i);
        mode_i = 4'b0000;
        cap_i  = lvl;
        repeat (4) @(negedge clk_i);
        mode_i     = m;
        rst_en_i   = ren;
        flag_clr_i = 1'b1;
        @(negedge clk_i);
        flag_clr_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [CNT_W-1:0] c, b, bp;
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        @(negedge clk_i);
        check("R12", "buf after reset", buf_o, 0);
        check("R12", "count after reset", count_o, 0);
        check("R12", "flag after reset", flag_o, 0);
        check("R12", "trig after reset", trig_o, 0);

        // R11: mode writes with timer stopped leave the count alone
        c = count_o;
        for (int i = 0; i < 16; i++) begin
            mode_i = 4'(i);
            @(negedge clk_i);
        end
        mode_i = 4'b0000;
        @(negedge clk_i);
        check("R11", "count after mode writes", count_o, c);
        tmr_en_i = 1'b1;
        repeat (5) @(negedge clk_i);
        check("R11", "count after 5 enabled clocks", count_o, c + 5);

        // Table of single-transition scenarios
        for (int k = 0; k < int'(NVEC); k++) begin
            logic [13:0] v;
            string       rq;
            v  = VEC[k];
            rq = $sformatf("R%0d", v[3:0]);
            prep(v[13:10], v[9], ~v[8]);
            bp    = buf_o;
            cap_i = v[8];
            repeat (2) @(negedge clk_i);
            c = count_o;
            b = buf_o;
            check("R1", "flag before third edge", flag_o, 0);
            check("R1", "trig before third edge", trig_o, 0);
            check("R1", "buf before third edge", b, bp);
            @(negedge clk_i);
            check(rq, "buf", buf_o, v[7] ? c : b);
            check(rq, "count", count_o, v[6] ? 0 : CNT_W'(c + 1));
            check(rq, "flag", flag_o, v[5]);
            check(rq, "trig", trig_o, v[4]);
        end

        // R10: clear strobe in the same cycle as a capture wins
        prep(4'b0001, 1'b0, 1'b0);
        cap_i = 1'b1;
        repeat (2) @(negedge clk_i);
        c = count_o;
        flag_clr_i = 1'b1;
        @(negedge clk_i);
        flag_clr_i = 1'b0;
        check("R10", "flag with simultaneous clear", flag_o, 0);
        check("R10", "capture still taken", buf_o, c);

        // R10: flag stays set without a clear
        cap_i = 1'b0;
        repeat (3) @(negedge clk_i);
        cap_i = 1'b1;
        repeat (8) @(negedge clk_i);
        check("R10", "flag sticky", flag_o, 1);
        flag_clr_i = 1'b1;
        @(negedge clk_i);
        flag_clr_i = 1'b0;
        check("R10", "flag after clear", flag_o, 0);

        // R7: trigger starts a stopped time base
        tmr_en_i = 1'b0;
        prep(4'b1110, 1'b0, 1'b0);
        c = count_o;
        cap_i = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R7", "count frozen before trigger", count_o, c);
        @(negedge clk_i);
        check("R7", "count cleared by trigger", count_o, 0);
        check("R7", "trig pulse", trig_o, 1);
        repeat (3) @(negedge clk_i);
        check("R7", "count runs after trigger", count_o, 3);
        check("R7", "flag not set by trigger", flag_o, 0);
        mode_i = 4'b0000;
        repeat (2) @(negedge clk_i);
        c = count_o;
        repeat (3) @(negedge clk_i);
        check("R11", "count holds after leaving trigger mode", count_o, c);

        report();
    end

endmodule